// File: doc/BRIEF.md
# Cascadable Multi-Enable Line Decoder

A combinational line decoder that turns a binary select code into a single active-low output line. The base unit handles 3 select bits and 8 lines. It is gated by three enable inputs of mixed polarity: one is active-high and two are active-low. The base unit decodes only while all three enables sit at their asserted levels. Under any other enable combination, every output stays inactive (high).

The top module packs several base units into one wider decoder. The low 3 select bits fan out to every unit. The upper select bits drive the unit enables, so that exactly one unit decodes at a time. A global enable then blanks the whole output vector.

A parameter chooses the width of the top module:
- With two bank bits (the default), four units form a 5-to-32 decoder.
- With one bank bit, two units form a 4-to-16 decoder. In this variant the fourth address bit reaches one unit on an active-low enable and the other unit on an active-high enable.

No part of the block holds state.

Top module: `wideLineDecoder`

## Requirements
- R1: When the base unit sees active-high enable = 1 and both active-low enables = 0, output bit number `sel` (0..7) is 0 and the other seven bits are 1.
- R2: For any of the other seven enable combinations, all 8 base-unit outputs are 1, whatever the select value.
- R3: The base unit never drives more than one output low at the same time.
- R4: With `enableIn` = 1, `lineOutN` bit number `selIn` (0..31) is 0 and all other bits are 1. `selIn[2:0]` picks the line inside a unit, and `selIn[4:3]` picks the unit.
- R5: With `enableIn` = 0, all 32 bits of `lineOutN` are 1 for every `selIn`.
- R6: Outputs are a pure function of the current inputs. A new input value appears at the outputs in the same time step, with no clock edge needed.
- R7: With BANK_BITS = 1, the block is a 4-to-16 decoder. Bit 3 of the select drives an active-low enable of the lower unit and the active-high enable of the upper unit. With the enable at 1, bit `sel` (0..15) of the output is 0. With the enable at 0, all 16 bits are 1.
- R8: With `enableIn` = 1, exactly one bit of `lineOutN` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| selIn | input | 5 | Binary line select; bits [4:3] choose the unit, bits [2:0] the line |
| enableIn | input | 1 | Global active-high enable |
| lineOutN | output | 32 | One-cold decoded lines, active-low |

## Verification
Every result is combinational, so each output is due in the same time step as the stimulus that causes it. No clock edge and no register lies on any path. The bench changes inputs on the falling edge of its clock and samples 2 ns later, well before the next rising edge. One directed check changes the select with no clock edge in between and expects the new line at once. The sweeps cover every select value against every enable combination. The expected values are computed in the bench as one-cold vectors.

// File: rtl/decPkg.sv
package decPkg;
  localparam int BASE_SEL_W = 3;
  localparam int BASE_LINES = 1 << BASE_SEL_W;

  typedef struct packed {
    logic decodeGo;
  } decStrobe_t;
endpackage

// File: rtl/decEnableCtl.sv
module decEnableCtl (
  input  logic               enHigh,
  input  logic               enLowAN,
  input  logic               enLowBN,
  output decPkg::decStrobe_t strobe
);
  always_comb begin
    strobe          = '0;
    strobe.decodeGo = enHigh & ~enLowAN & ~enLowBN;
  end
endmodule

// File: rtl/decOutputPath.sv
module decOutputPath #(
  parameter int SEL_W = decPkg::BASE_SEL_W,
  localparam int LINES = 1 << SEL_W
) (
  input  logic [SEL_W-1:0]   sel,
  input  decPkg::decStrobe_t strobe,
  output logic [LINES-1:0]   lineN
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign lineN[i] = ~(strobe.decodeGo && (sel == SEL_W'(i)));
  end

  always_comb begin
    if (!$isunknown({sel, strobe, lineN})) begin
      // R2
      blank_when_off_chk: assert (strobe.decodeGo || (&lineN))
        else $error("lines active while decode strobe low");
      // R3
      single_low_chk: assert ($countones(~lineN) <= 1)
        else $error("more than one line low");
    end
  end
endmodule

// File: rtl/decoder3to8.sv
module decoder3to8 (
  input  logic [decPkg::BASE_SEL_W-1:0] sel,
  input  logic                          enHigh,
  input  logic                          enLowAN,
  input  logic                          enLowBN,
  output logic [decPkg::BASE_LINES-1:0] lineN
);
  decPkg::decStrobe_t strobe;

  decEnableCtl u_ctl (
    .enHigh (enHigh),
    .enLowAN(enLowAN),
    .enLowBN(enLowBN),
    .strobe (strobe)
  );

  decOutputPath #(.SEL_W(decPkg::BASE_SEL_W)) u_path (
    .sel   (sel),
    .strobe(strobe),
    .lineN (lineN)
  );

  always_comb begin
    if (!$isunknown({sel, enHigh, enLowAN, enLowBN, lineN})) begin
      // R1
      selected_low_chk: assert (!(enHigh && !enLowAN && !enLowBN) || (lineN[sel] == 1'b0))
        else $error("selected line not low under decode pattern");
    end
  end
endmodule

// File: rtl/decBankSelect.sv
module decBankSelect #(
  parameter int BANK_BITS = 2,
  localparam int UNITS = 1 << BANK_BITS
) (
  input  logic [BANK_BITS-1:0] bankSel,
  input  logic                 globalEn,
  output logic [UNITS-1:0]     enHigh,
  output logic [UNITS-1:0]     enLowAN,
  output logic [UNITS-1:0]     enLowBN
);
  if (BANK_BITS == 1) begin : g_pair
    // Upper address bit steers the two units through opposite-polarity enables.
    assign enHigh[0]  = globalEn;
    assign enLowAN[0] = bankSel[0];
    assign enLowBN[0] = 1'b0;
    assign enHigh[1]  = bankSel[0];
    assign enLowAN[1] = ~globalEn;
    assign enLowBN[1] = 1'b0;
  end else begin : g_bank
    for (genvar u = 0; u < UNITS; u++) begin : g_unit
      assign enHigh[u]  = globalEn;
      assign enLowAN[u] = (bankSel != BANK_BITS'(u));
      assign enLowBN[u] = ~globalEn;
    end
  end
endmodule

// File: rtl/wideLineDecoder.sv
module wideLineDecoder #(
  parameter int BANK_BITS = 2,
  localparam int SEL_W = decPkg::BASE_SEL_W + BANK_BITS,
  localparam int UNITS = 1 << BANK_BITS,
  localparam int LINES = decPkg::BASE_LINES * UNITS
) (
  input  logic [SEL_W-1:0] selIn,
  input  logic             enableIn,
  output logic [LINES-1:0] lineOutN
);
  localparam int BW = decPkg::BASE_SEL_W;
  localparam int BL = decPkg::BASE_LINES;

  logic [UNITS-1:0] unitEnHigh;
  logic [UNITS-1:0] unitEnLowAN;
  logic [UNITS-1:0] unitEnLowBN;

  decBankSelect #(.BANK_BITS(BANK_BITS)) u_bank (
    .bankSel (selIn[SEL_W-1:BW]),
    .globalEn(enableIn),
    .enHigh  (unitEnHigh),
    .enLowAN (unitEnLowAN),
    .enLowBN (unitEnLowBN)
  );

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    decoder3to8 u_unit (
      .sel    (selIn[BW-1:0]),
      .enHigh (unitEnHigh[u]),
      .enLowAN(unitEnLowAN[u]),
      .enLowBN(unitEnLowBN[u]),
      .lineN  (lineOutN[u*BL +: BL])
    );
  end

  always_comb begin
    if (!$isunknown({selIn, enableIn, lineOutN})) begin
      // R5
      global_off_chk: assert (enableIn || (&lineOutN))
        else $error("lines active with global enable low");
      // R8
      one_cold_chk: assert (!enableIn || ($countones(~lineOutN) == 1))
        else $error("not exactly one line low");
      // R4
      addressed_line_chk: assert (!enableIn || (lineOutN[selIn] == 1'b0))
        else $error("addressed line not low");
    end
  end
endmodule

// File: tb/wideLineDecoder_tb.sv
module wideLineDecoder_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [4:0]  selIn = '0;
  logic        enableIn = 1'b0;
  logic [31:0] lineOutN;

  logic [3:0]  sel16 = '0;
  logic        en16 = 1'b0;
  logic [15:0] line16N;

  logic [2:0]  bSel = '0;
  logic        bHigh = 1'b0, bLowA = 1'b1, bLowB = 1'b1;
  logic [7:0]  bLineN;

  wideLineDecoder u_dut (.selIn(selIn), .enableIn(enableIn), .lineOutN(lineOutN));
  wideLineDecoder #(.BANK_BITS(1)) u_dut16 (.selIn(sel16), .enableIn(en16), .lineOutN(line16N));
  decoder3to8 u_base (.sel(bSel), .enHigh(bHigh), .enLowAN(bLowA), .enLowBN(bLowB), .lineN(bLineN));

  // {enable, select, expected lines}
  localparam logic [37:0] VEC [8] = '{
    {1'b0, 5'd0,  32'hFFFF_FFFF},
    {1'b1, 5'd0,  32'hFFFF_FFFE},
    {1'b1, 5'd7,  32'hFFFF_FF7F},
    {1'b1, 5'd8,  32'hFFFF_FEFF},
    {1'b1, 5'd16, 32'hFFFE_FFFF},
    {1'b1, 5'd24, 32'hFEFF_FFFF},
    {1'b1, 5'd31, 32'h7FFF_FFFF},
    {1'b0, 5'd31, 32'hFFFF_FFFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    #2;
    // R5 / R6: state during bench reset, global enable low
    chk("R5 reset", lineOutN, 32'hFFFF_FFFF);
    chk("R2 reset base", {24'h0, bLineN}, 32'h0000_00FF);
    rst = 1'b0;

    // Vector table, R4 and R5
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      {enableIn, selIn} = VEC[i][37:32];
      #2;
      chk(VEC[i][37] ? "R4 table" : "R5 table", lineOutN, VEC[i][31:0]);
    end

    // Exhaustive wrapper sweep: R4, R5, R8
    for (int e = 0; e < 2; e++) begin
      for (int s = 0; s < 32; s++) begin
        @(negedge clk);
        enableIn = e[0];
        selIn = 5'(s);
        #2;
        if (e == 1) begin
          chk("R4 sweep", lineOutN, ~(32'd1 << s));
          chk("R8 count", 32'($countones(~lineOutN)), 32'd1);
        end else begin
          chk("R5 sweep", lineOutN, 32'hFFFF_FFFF);
        end
      end
    end

    // Base unit: all select values against all enable patterns, R1 R2 R3
    for (int p = 0; p < 8; p++) begin
      for (int s = 0; s < 8; s++) begin
        @(negedge clk);
        {bHigh, bLowA, bLowB} = 3'(p);
        bSel = 3'(s);
        #2;
        if (p == 4) chk("R1 base", {24'h0, bLineN}, {24'h0, ~(8'd1 << s)});
        else        chk("R2 base", {24'h0, bLineN}, 32'h0000_00FF);
        chk("R3 base", {31'h0, ($countones(~bLineN) <= 1)}, 32'd1);
      end
    end

    // 4-to-16 variant, R7
    for (int e = 0; e < 2; e++) begin
      for (int s = 0; s < 16; s++) begin
        @(negedge clk);
        en16 = e[0];
        sel16 = 4'(s);
        #2;
        chk("R7 pair", {16'h0, line16N}, {16'h0, (e == 1) ? ~(16'd1 << s) : 16'hFFFF});
      end
    end

    // R6: change inputs between clock edges, output follows immediately
    @(posedge clk);
    #1;
    enableIn = 1'b1;
    selIn = 5'd19;
    #1;
    chk("R6 no edge", lineOutN, ~(32'd1 << 19));
    selIn = 5'd4;
    #1;
    chk("R6 follow", lineOutN, ~(32'd1 << 4));
    enableIn = 1'b0;
    #1;
    chk("R6 blank", lineOutN, 32'hFFFF_FFFF);

    finished = 1'b1;
    summary();
  end
endmodule